// File: doc/BRIEF.md
# Reload-and-Match PWM Timer

This block produces a pulse-width-modulated output from an up-counting timer. The counter climbs from a load value to the all-ones count and then reloads, so one output period lasts exactly the requested number of clock cycles. The output is active from the load value up to and including a match value. It is inactive from just after the match value until the counter wraps.

A requester supplies a period and an active duration, both counted in clock cycles, and pulses a configuration strobe. The block checks the request and, if it is usable, converts it into load and match values. A period shorter than two cycles is refused, and the refusal is flagged. An active duration outside the achievable range is pulled back into range.

An accepted request is first held in a shadow copy. While the timer runs, the shadow copy takes over only at the wrap, so a period in progress is never cut short. While the timer is disabled, the shadow copy is applied on the next clock. The load and match values that are currently applied are visible on the outputs.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset, pwmOut and cfgError are 0, the applied loadValue and matchValue are 0, and the timer stays idle until enable is asserted.
- R2: For an accepted period P, the applied load value is 2^W - P, which is all-ones minus P plus one.
- R3: For an accepted request, the applied match value is the load value plus the effective active duration minus one.
- R4: A strobe whose period is below 2 sets cfgError to 1 on the next edge and leaves both the shadow configuration and the applied configuration unchanged.
- R5: An active duration of 0 is treated as 1, so the match value equals the load value.
- R6: An active duration greater than or equal to the period is treated as period minus 1, so the match value is all-ones minus 1.
- R7: The applied values always satisfy loadValue <= matchValue and matchValue != all-ones.
- R8: While enabled, pwmOut is 1 for the first D cycles of each period of P cycles and 0 for the remaining P - D cycles, where D is the effective duration. After the counter reaches all-ones it reloads the load value on the next edge.
- R9: While enabled, a configuration accepted in the middle of a period changes loadValue and matchValue only at the edge where the counter wraps from all-ones.
- R10: A strobe that carries a period of 2 or more clears cfgError on the next edge.
- R11: While enable is 0, pwmOut is 0, the counter is held at the shadow load value, and the shadow values are applied on every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the counter when 1; holds it idle when 0 |
| cfgStrobe | input | 1 | One-cycle request to take periodCycles and dutyCycles |
| periodCycles | input | CNT_W | Requested period in clock cycles |
| dutyCycles | input | CNT_W | Requested active duration in clock cycles |
| pwmOut | output | 1 | PWM output, active high |
| cfgError | output | 1 | 1 after a strobe that was refused |
| loadValue | output | CNT_W | Load value currently applied |
| matchValue | output | CNT_W | Match value currently applied |

## Verification
- **cfgError:** it is due one rising edge after the strobe.
- **Applied values, timer disabled:** the request is written to the shadow copy at the strobe edge and reaches loadValue and matchValue one edge later.
- **Applied values, timer running:** they change only at the wrap edge.
- **pwmOut:** it is decoded from the counter without a register, so it follows a change of enable within the same cycle and otherwise changes one edge after the counter moves.
- **Sampling:** the bench drives all inputs and samples all outputs one time unit after each rising edge. A reference model in the bench advances its counter, shadow state and applied state at that same edge, using only the values that were present before the edge.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

  // Strobes passed from the configuration control to the counter datapath
  typedef struct packed {
    logic wrShadow;  // accepted request: capture new load/match into shadow
    logic wrError;   // any request: update the error flag
    logic errVal;    // value for the error flag
  } cfgStrobes_t;

endpackage

// File: rtl/pwm_cfg_ctrl.sv
module pwm_cfg_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgStrobe,
  input  logic [CNT_W-1:0] periodCycles,
  input  logic [CNT_W-1:0] dutyCycles,
  output cfgStrobes_t      cmd,
  output logic [CNT_W-1:0] newLoad,
  output logic [CNT_W-1:0] newMatch,
  output logic             cfgError
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] MIN_PER  = {{(CNT_W-2){1'b0}}, 2'b10};

  logic             periodOk;
  logic [CNT_W-1:0] dutyEff;

  assign periodOk = (periodCycles >= MIN_PER);

  // Clamp the active duration into [1, period-1]
  always_comb begin
    if (dutyCycles == '0)
      dutyEff = ONE;
    else if (dutyCycles >= periodCycles)
      dutyEff = periodCycles - ONE;
    else
      dutyEff = dutyCycles;
  end

  assign newLoad  = (ALL_ONES - periodCycles) + ONE;
  assign newMatch = newLoad + dutyEff - ONE;

  always_comb begin
    cmd.wrShadow = cfgStrobe && periodOk;
    cmd.wrError  = cfgStrobe;
    cmd.errVal   = !periodOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cfgError <= 1'b0;
    else if (cmd.wrError)
      cfgError <= cmd.errVal;
  end

  p_reject_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStrobe && periodCycles < MIN_PER) |=> cfgError);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStrobe && periodCycles >= MIN_PER) |=> !cfgError);

  p_duty_floor_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStrobe && periodOk && dutyCycles == '0) |-> (newMatch == newLoad));

  p_duty_ceil_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStrobe && periodOk && dutyCycles >= periodCycles) |-> (newMatch == ALL_ONES - ONE));

endmodule

// File: rtl/pwm_counter_dp.sv
module pwm_counter_dp
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  cfgStrobes_t      cmd,
  input  logic [CNT_W-1:0] newLoad,
  input  logic [CNT_W-1:0] newMatch,
  output logic             pwmOut,
  output logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] matchValue
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] shadowLoad, shadowMatch;
  logic [CNT_W-1:0] loadApplied, matchApplied;
  logic [CNT_W-1:0] count;
  logic             atTop;
  logic             swap;

  assign atTop = (count == ALL_ONES);
  assign swap  = !enable || atTop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowLoad  <= '0;
      shadowMatch <= '0;
    end else if (cmd.wrShadow) begin
      shadowLoad  <= newLoad;
      shadowMatch <= newMatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadApplied  <= '0;
      matchApplied <= '0;
    end else if (swap) begin
      loadApplied  <= shadowLoad;
      matchApplied <= shadowMatch;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (swap)
      count <= shadowLoad;
    else
      count <= count + ONE;
  end

  assign pwmOut     = enable && (count >= loadApplied) && (count <= matchApplied);
  assign loadValue  = loadApplied;
  assign matchValue = matchApplied;

  p_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    (loadApplied <= matchApplied) && (matchApplied != ALL_ONES));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !atTop) |=> ($stable(loadApplied) && $stable(matchApplied)));

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enable && atTop) |=> (count == $past(shadowLoad)));

  p_idle_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !pwmOut);

  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.wrShadow |=> ($stable(shadowLoad) && $stable(shadowMatch)));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             cfgStrobe,
  input  logic [CNT_W-1:0] periodCycles,
  input  logic [CNT_W-1:0] dutyCycles,
  output logic             pwmOut,
  output logic             cfgError,
  output logic [CNT_W-1:0] loadValue,
  output logic [CNT_W-1:0] matchValue
);

  cfgStrobes_t      cmd;
  logic [CNT_W-1:0] newLoad, newMatch;

  pwm_cfg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .cfgStrobe    (cfgStrobe),
    .periodCycles (periodCycles),
    .dutyCycles   (dutyCycles),
    .cmd          (cmd),
    .newLoad      (newLoad),
    .newMatch     (newMatch),
    .cfgError     (cfgError)
  );

  pwm_counter_dp #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cmd        (cmd),
    .newLoad    (newLoad),
    .newMatch   (newMatch),
    .pwmOut     (pwmOut),
    .loadValue  (loadValue),
    .matchValue (matchValue)
  );

endmodule

// File: tb/tb_pwm_reload_timer.sv
module tb_pwm_reload_timer;

  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] MAXV       = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        cfgStrobe = 1'b0;
  logic [31:0] periodCycles = '0;
  logic [31:0] dutyCycles = '0;
  logic        pwmOut, cfgError;
  logic [31:0] loadValue, matchValue;

  int tests = 0;
  int fails = 0;

  // reference model state
  logic [31:0] mCnt = '0, mLoad = '0, mMatch = '0, pLoad = '0, pMatch = '0;
  logic        mErr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reload_timer #(.CNT_W(32)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgStrobe(cfgStrobe),
    .periodCycles(periodCycles), .dutyCycles(dutyCycles),
    .pwmOut(pwmOut), .cfgError(cfgError),
    .loadValue(loadValue), .matchValue(matchValue)
  );

  function automatic logic [31:0] fLoad(input logic [31:0] p);
    return (MAXV - p) + 32'd1;
  endfunction

  function automatic logic [31:0] fDuty(input logic [31:0] p, input logic [31:0] d);
    if (d == 0) return 32'd1;
    if (d >= p) return p - 32'd1;
    return d;
  endfunction

  function automatic logic [31:0] fMatch(input logic [31:0] p, input logic [31:0] d);
    return fLoad(p) + fDuty(p, d) - 32'd1;
  endfunction

  task automatic chkBit(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelEdge(input logic s, input logic [31:0] p, input logic [31:0] d);
    if (!enable || mCnt == MAXV) begin
      mLoad  = pLoad;
      mMatch = pMatch;
      mCnt   = pLoad;
    end else begin
      mCnt = mCnt + 32'd1;
    end
    if (s) begin
      if (p < 2) mErr = 1'b1;
      else begin
        mErr   = 1'b0;
        pLoad  = fLoad(p);
        pMatch = fMatch(p, d);
      end
    end
  endtask

  task automatic compareAll();
    chkBit("R8 pwmOut", pwmOut, enable && mCnt >= mLoad && mCnt <= mMatch);
    chk32("R9 loadValue", loadValue, mLoad);
    chk32("R9 matchValue", matchValue, mMatch);
    chkBit("R4 cfgError", cfgError, mErr);
    chkBit("R7 order", (loadValue <= matchValue) && (matchValue != MAXV), 1'b1);
  endtask

  task automatic step(input logic s, input logic [31:0] p, input logic [31:0] d);
    cfgStrobe    = s;
    periodCycles = p;
    dutyCycles   = d;
    @(posedge clk);
    modelEdge(s, p, d);
    #1;
    cfgStrobe = 1'b0;
    compareAll();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL R8 watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4711);
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chkBit("R1 pwmOut", pwmOut, 1'b0);
    chkBit("R1 cfgError", cfgError, 1'b0);
    chk32("R1 loadValue", loadValue, 32'd0);
    chk32("R1 matchValue", matchValue, 32'd0);
    rstN = 1'b1;
    step(1'b0, 0, 0);
    chkBit("R1 idle pwmOut", pwmOut, 1'b0);

    // R4: short period refused
    step(1'b1, 32'd1, 32'd0);
    chkBit("R4 error set", cfgError, 1'b1);
    step(1'b0, 0, 0);
    chk32("R4 load unchanged", loadValue, 32'd0);
    step(1'b1, 32'd0, 32'd3);
    chkBit("R4 error zero period", cfgError, 1'b1);

    // R10 / R2 / R5
    step(1'b1, 32'd10, 32'd0);
    chkBit("R10 error cleared", cfgError, 1'b0);
    step(1'b0, 0, 0);
    chk32("R2 load period 10", loadValue, 32'hFFFF_FFF6);
    chk32("R5 match duty 0", matchValue, 32'hFFFF_FFF6);

    // R6
    step(1'b1, 32'd10, 32'd10);
    step(1'b0, 0, 0);
    chk32("R6 match clamped", matchValue, 32'hFFFF_FFFE);
    step(1'b1, 32'd2, 32'd7);
    step(1'b0, 0, 0);
    chk32("R6 load period 2", loadValue, 32'hFFFF_FFFE);
    chk32("R6 match period 2", matchValue, 32'hFFFF_FFFE);

    // R2 / R3 at the widest period
    step(1'b1, MAXV, 32'd5);
    step(1'b0, 0, 0);
    chk32("R2 load max period", loadValue, 32'd1);
    chk32("R3 match max period", matchValue, 32'd5);

    // R8: period 5, duty 2 -> 1,1,0,0,0,1,1
    step(1'b1, 32'd5, 32'd2);
    step(1'b0, 0, 0);
    enable = 1'b1;
    #1;
    chkBit("R8 first active", pwmOut, 1'b1);
    begin
      logic pat [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
      for (int i = 0; i < 6; i++) begin
        step(1'b0, 0, 0);
        chkBit("R8 pattern", pwmOut, pat[i]);
      end
    end

    // R9: mid-period change waits for the wrap (now at position 1)
    step(1'b1, 32'd3, 32'd1);
    chk32("R9 load held mid-period", loadValue, fLoad(32'd5));
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    chk32("R9 load held before wrap", loadValue, fLoad(32'd5));
    step(1'b0, 0, 0);
    chk32("R9 load after wrap", loadValue, fLoad(32'd3));
    chk32("R9 match after wrap", matchValue, fMatch(32'd3, 32'd1));

    // R11: disabled output stays low
    enable = 1'b0;
    #1;
    chkBit("R11 pwm low on disable", pwmOut, 1'b0);
    step(1'b0, 0, 0);
    chkBit("R11 pwm low idle", pwmOut, 1'b0);
    step(1'b1, 32'd7, 32'd3);
    step(1'b0, 0, 0);
    chk32("R11 idle apply", loadValue, fLoad(32'd7));
    enable = 1'b1;
    #1;

    // constrained random run
    for (int n = 0; n < 4000; n++) begin
      if ($urandom % 150 == 0) begin
        enable = ~enable;
        #1;
        chkBit("R11 enable change", pwmOut, enable && mCnt >= mLoad && mCnt <= mMatch);
      end
      if ($urandom % 10 == 0)
        step(1'b1, 32'($urandom % 26), 32'($urandom % 30));
      else
        step(1'b0, 0, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule